// File: doc/BRIEF.md
# Dual-Mode Flash Bus Front End

This block is the host-facing bus front end of a 32-bit-wide flash-style memory model. It decodes chip enable, output enable, a separate output-disable pin, write enable, a load-address pin, a read/command select and an active-low reset/power-down. From these it produces internal read, write, address-latch and command-latch strobes and a drive-enable for the data bus. The bus is modelled as a data value plus a separate drive-enable, so a high-impedance state shows as `dout_en` low.

The interface has two modes. In asynchronous mode, read data follows the address pins directly. A write is taken on the clock edge that sees chip enable and write enable low, and its low data byte is a command. In synchronous mode, an address is loaded into a burst counter on a clock edge with the load-address pin low. Read data is then registered from the counter on each read edge, and the counter advances and wraps at the top of a small internal array. A select pin chooses whether a loaded address is a read address or the target of a command. A toggle command switches between the modes. A signature mode returns identification words in place of array contents.

Top module: `fbus_front`

## Requirements
- R1: While `rst_pd_n` is low, `dout_en` is 0 whatever the other pins are. Releasing reset leaves the block in asynchronous mode, with signature mode off and every array word zero.
- R2: With `ce_n` high, `dout_en` and all four strobes are 0.
- R3: In asynchronous mode, `dout_en` is 1 when `ce_n`=0, `oe_n`=0, `odis_n`=1 and `we_n`=1. `dout` then equals the addressed word. `rd_stb` is 1 while `ce_n` is low and `lba_n` is low after having been high at the previous clock edge.
- R4: `odis_n`=0 or `oe_n`=1 forces `dout_en` to 0, even when the other pins call for a read.
- R5: In asynchronous mode, a clock edge with `ce_n`=0, `we_n`=0 and `oe_n`=1 takes `din[7:0]` as a command, and `wr_stb` is 1 during that cycle. 0x90 enters signature mode, 0xFF leaves it, 0xE0 toggles between asynchronous and synchronous mode, and other values are ignored.
- R6: In signature mode, the read word depends on address bits [1:0] only: 00 gives 0x00000020, 01 gives 0x000000F0, 10 gives 0x0000000v (v = the VERSION parameter, 0..7) and 11 gives 0.
- R7: In synchronous mode, a clock edge with `ce_n`=0 and `lba_n`=0 loads `addr[IDX_W-1:0]` into the burst counter. With `wr_sel`=1 this is a read address and `alat_stb` is 1. With `wr_sel`=0 it is a command address and `clat_stb` is 1.
- R8: In synchronous mode, a clock edge with `ce_n`=0, `lba_n`=1, `we_n`=0 and `oe_n`=1 is a data write, and `wr_stb` is 1. After a command address, `din[7:0]` is executed as a command as in R5. Otherwise `din` is stored at the counter address, and the counter is left unchanged.
- R9: In synchronous mode, each clock edge with `ce_n`=0, `oe_n`=0, `we_n`=1 and `lba_n`=1 registers the word at the counter onto `dout` and increments the counter, wrapping from DEPTH-1 to 0. `dout_en` is 1 only in the cycle after such an edge, so it is 0 before the first read edge.
- R10: In synchronous mode, the address pins have no effect on `dout` except at a load edge.
- R11: In asynchronous mode, `lba_n` low never raises `alat_stb` or `clat_stb`. A synchronous command write of 0xE0 returns the block to asynchronous reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_pd_n | input | 1 | Reset/power-down, active low, asynchronous |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| odis_n | input | 1 | Output disable, active low |
| we_n | input | 1 | Write enable, active low |
| lba_n | input | 1 | Load burst address, active low |
| wr_sel | input | 1 | 1: read address, 0: command address |
| addr | input | ADDR_W | Address pins |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data |
| dout_en | output | 1 | Bus drive enable (0 = high impedance) |
| rd_stb | output | 1 | Internal read strobe |
| wr_stb | output | 1 | Internal write strobe |
| alat_stb | output | 1 | Read-address latch strobe |
| clat_stb | output | 1 | Command-address latch strobe |

## Verification
Asynchronous reads are tried with array and signature contents, and with high address bits set, which shows that only the low index bits select a word. Burst reads start near the top of the array, so the wrap from DEPTH-1 to 0 can be told apart from a saturating counter. The address pins are moved in the middle of the burst, which separates a counter-driven read from one that follows the pins. Command-latched and read-latched writes carry the same code values, so a write is only counted correct when it is steered to the right target. Output-disable, output-enable and reset are each driven against an otherwise valid read, so each gating path is seen on its own.

// File: rtl/fbus_pkg.sv
package fbus_pkg;
    localparam logic [7:0] CMD_ARRAY  = 8'hFF;
    localparam logic [7:0] CMD_SIG    = 8'h90;
    localparam logic [7:0] CMD_TOGGLE = 8'hE0;

    localparam logic [7:0] SIG_MAKER  = 8'h20;
    localparam logic [7:0] SIG_DEVICE = 8'hF0;

    typedef struct packed {
        logic rd;
        logic wr;
        logic alat;
        logic clat;
    } strobe_t;
endpackage

// File: rtl/fbus_pin_decode.sv
module fbus_pin_decode
    import fbus_pkg::*;
(
    input  logic    rst_pd_n,
    input  logic    ce_n,
    input  logic    oe_n,
    input  logic    odis_n,
    input  logic    we_n,
    input  logic    lba_n,
    input  logic    wr_sel,
    input  logic    sync_mode,
    input  logic    lba_prev,
    output strobe_t stb,
    output logic    async_wr,
    output logic    sync_wr,
    output logic    sync_rd,
    output logic    drive_ok
);
    logic sel;
    logic async_rd;

    always_comb begin
        sel      = rst_pd_n & ~ce_n;
        async_rd = sel & ~sync_mode & lba_prev & ~lba_n;
        async_wr = sel & ~sync_mode & ~we_n & oe_n;
        sync_rd  = sel & sync_mode & lba_n & ~oe_n & we_n;
        sync_wr  = sel & sync_mode & lba_n & ~we_n & oe_n;
        stb.rd   = async_rd | sync_rd;
        stb.wr   = async_wr | sync_wr;
        stb.alat = sel & sync_mode & ~lba_n & wr_sel;
        stb.clat = sel & sync_mode & ~lba_n & ~wr_sel;
        drive_ok = sel & ~oe_n & odis_n & we_n;
    end
endmodule

// File: rtl/fbus_read_mux.sv
module fbus_read_mux
    import fbus_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int DEPTH   = 16,
    parameter int IDX_W   = 4,
    parameter int VERSION = 0
) (
    input  logic [DEPTH-1:0][DATA_W-1:0] mem,
    input  logic [IDX_W-1:0]             idx,
    input  logic                         sig_mode,
    output logic [DATA_W-1:0]            data
);
    logic [DATA_W-1:0] sig_word;

    always_comb begin
        sig_word = '0;
        unique case (idx[1:0])
            2'b00: sig_word[7:0] = SIG_MAKER;
            2'b01: sig_word[7:0] = SIG_DEVICE;
            2'b10: sig_word[2:0] = 3'(VERSION);
            default: sig_word = '0;
        endcase
        data = sig_mode ? sig_word : mem[idx];
    end
endmodule

// File: rtl/fbus_front.sv
module fbus_front
    import fbus_pkg::*;
#(
    parameter int ADDR_W  = 18,
    parameter int DATA_W  = 32,
    parameter int DEPTH   = 16,
    parameter int VERSION = 5
) (
    input  logic              clk,
    input  logic              rst_pd_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              odis_n,
    input  logic              we_n,
    input  logic              lba_n,
    input  logic              wr_sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    output logic              rd_stb,
    output logic              wr_stb,
    output logic              alat_stb,
    output logic              clat_stb
);
    localparam int IDX_W = (DEPTH > 4) ? $clog2(DEPTH) : 2;

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [IDX_W-1:0]             cnt;
        logic [DATA_W-1:0]            data;
        logic                         valid;
        logic                         sync;
        logic                         sig;
        logic                         cmd_pend;
        logic                         lba_prev;
    } state_t;

    state_t st_d, st_q;

    strobe_t           stb;
    logic              async_wr, sync_wr, sync_rd, drive_ok;
    logic [DATA_W-1:0] async_rdata, sync_rdata;
    logic [IDX_W-1:0]  burst_ptr;
    logic              sync_mode;

    assign burst_ptr = st_q.cnt;
    assign sync_mode = st_q.sync;

    fbus_pin_decode u_dec (
        .rst_pd_n (rst_pd_n),
        .ce_n     (ce_n),
        .oe_n     (oe_n),
        .odis_n   (odis_n),
        .we_n     (we_n),
        .lba_n    (lba_n),
        .wr_sel   (wr_sel),
        .sync_mode(st_q.sync),
        .lba_prev (st_q.lba_prev),
        .stb      (stb),
        .async_wr (async_wr),
        .sync_wr  (sync_wr),
        .sync_rd  (sync_rd),
        .drive_ok (drive_ok)
    );

    fbus_read_mux #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W), .VERSION(VERSION)) u_amux (
        .mem     (st_q.mem),
        .idx     (addr[IDX_W-1:0]),
        .sig_mode(st_q.sig),
        .data    (async_rdata)
    );

    fbus_read_mux #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W), .VERSION(VERSION)) u_smux (
        .mem     (st_q.mem),
        .idx     (st_q.cnt),
        .sig_mode(st_q.sig),
        .data    (sync_rdata)
    );

    function automatic state_t run_cmd(input state_t s, input logic [7:0] code);
        state_t r = s;
        r.cmd_pend = 1'b0;
        unique case (code)
            CMD_ARRAY:  r.sig = 1'b0;
            CMD_SIG:    r.sig = 1'b1;
            CMD_TOGGLE: r.sync = ~s.sync;
            default:    r.sig = s.sig;
        endcase
        return r;
    endfunction

    always_comb begin
        st_d          = st_q;
        st_d.lba_prev = lba_n;
        st_d.valid    = 1'b0;
        if (async_wr) begin
            st_d = run_cmd(st_d, din[7:0]);
        end
        if (stb.alat || stb.clat) begin
            st_d.cnt      = addr[IDX_W-1:0];
            st_d.cmd_pend = stb.clat;
        end
        if (sync_wr) begin
            if (st_q.cmd_pend) begin
                st_d = run_cmd(st_d, din[7:0]);
            end else begin
                st_d.mem[st_q.cnt] = din;
            end
        end
        if (sync_rd) begin
            st_d.data  = sync_rdata;
            st_d.cnt   = st_q.cnt + 1'b1;
            st_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_pd_n) begin
        if (!rst_pd_n) begin
            st_q          <= '0;
            st_q.lba_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        dout     = st_q.sync ? st_q.data : async_rdata;
        dout_en  = drive_ok & (~st_q.sync | st_q.valid);
        rd_stb   = stb.rd;
        wr_stb   = stb.wr;
        alat_stb = stb.alat;
        clat_stb = stb.clat;
    end
endmodule

// File: rtl/fbus_front_chk.sv
module fbus_front_chk #(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4
) (
    input logic              clk,
    input logic              rst_pd_n,
    input logic              ce_n,
    input logic              oe_n,
    input logic              odis_n,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] din,
    input logic              dout_en,
    input logic              rd_stb,
    input logic              wr_stb,
    input logic              alat_stb,
    input logic              clat_stb,
    input logic              sync_mode,
    input logic [IDX_W-1:0]  burst_ptr
);
    always @(negedge clk) begin
        assert_reset_hiz_R1: assert (rst_pd_n || !dout_en)
            else $error("bus driven during reset");
        assert_standby_quiet_R2: assert (!ce_n || !(dout_en || rd_stb || wr_stb || alat_stb || clat_stb))
            else $error("activity in standby");
        assert_disable_hiz_R4: assert ((odis_n && !oe_n) || !dout_en)
            else $error("bus driven while disabled");
    end

    property p_toggle;
        @(posedge clk) disable iff (!rst_pd_n)
            (!sync_mode && wr_stb && din[7:0] == 8'hE0) |=> sync_mode;
    endproperty
    assert_toggle_R5: assert property (p_toggle) else $error("toggle ignored");

    property p_latch;
        @(posedge clk) disable iff (!rst_pd_n)
            (alat_stb || clat_stb) |=> (burst_ptr == $past(addr[IDX_W-1:0]));
    endproperty
    assert_latch_R7: assert property (p_latch) else $error("address not loaded");

    property p_burst;
        @(posedge clk) disable iff (!rst_pd_n)
            (sync_mode && rd_stb) |=> (burst_ptr == IDX_W'($past(burst_ptr) + 1'b1));
    endproperty
    assert_burst_step_R9: assert property (p_burst) else $error("counter did not step");
endmodule

bind fbus_front fbus_front_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
    .clk      (clk),
    .rst_pd_n (rst_pd_n),
    .ce_n     (ce_n),
    .oe_n     (oe_n),
    .odis_n   (odis_n),
    .addr     (addr),
    .din      (din),
    .dout_en  (dout_en),
    .rd_stb   (rd_stb),
    .wr_stb   (wr_stb),
    .alat_stb (alat_stb),
    .clat_stb (clat_stb),
    .sync_mode(sync_mode),
    .burst_ptr(burst_ptr)
);

// File: tb/fbus_front_test.sv
`timescale 1ns/100ps
module fbus_front_test;
    localparam int ADDR_W = 18;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_pd_n, ce_n, oe_n, odis_n, we_n, lba_n, wr_sel;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] din, dout;
    logic              dout_en, rd_stb, wr_stb, alat_stb, clat_stb;
    int                n_chk = 0, n_fail = 0;
    bit                done = 1'b0;

    always #2 clk = ~clk;

    fbus_front #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(16), .VERSION(5)) uut (
        .clk(clk), .rst_pd_n(rst_pd_n), .ce_n(ce_n), .oe_n(oe_n), .odis_n(odis_n),
        .we_n(we_n), .lba_n(lba_n), .wr_sel(wr_sel), .addr(addr), .din(din),
        .dout(dout), .dout_en(dout_en), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .alat_stb(alat_stb), .clat_stb(clat_stb)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        ce_n = 1; oe_n = 1; odis_n = 1; we_n = 1; lba_n = 1; wr_sel = 1; din = '0;
    endtask

    task automatic async_cmd(input logic [7:0] code);
        idle(); ce_n = 0; we_n = 0; din = {24'h0, code};
        #1 chk("R5 async write strobe", {31'h0, wr_stb}, 32'h1);
        tick(); idle();
    endtask

    task automatic async_read(input string tag, input logic [ADDR_W-1:0] a, input logic [31:0] exp);
        idle(); ce_n = 0; oe_n = 0; addr = a;
        #1 chk({tag, " en"}, {31'h0, dout_en}, 32'h1);
        chk(tag, dout, exp);
        tick(); idle();
    endtask

    task automatic sync_latch(input logic [ADDR_W-1:0] a, input logic rd);
        idle(); ce_n = 0; lba_n = 0; wr_sel = rd; addr = a;
        #1 chk(rd ? "R7 alat" : "R7 clat", {30'h0, alat_stb, clat_stb}, rd ? 32'h2 : 32'h1);
        tick(); idle();
    endtask

    task automatic sync_wdata(input logic [31:0] d);
        idle(); ce_n = 0; we_n = 0; din = d;
        #1 chk("R8 sync write strobe", {31'h0, wr_stb}, 32'h1);
        tick(); idle();
    endtask

    task automatic t_reset();
        idle(); rst_pd_n = 0; ce_n = 0; oe_n = 0; addr = '0;
        tick(); tick();
        chk("R1 hiz in reset", {31'h0, dout_en}, 32'h0);
        rst_pd_n = 1; tick();
        async_read("R1 async after reset", 18'h3, 32'h0);
    endtask

    task automatic t_standby();
        idle(); oe_n = 0; lba_n = 0; we_n = 0;
        #1 chk("R2 standby", {27'h0, dout_en, rd_stb, wr_stb, alat_stb, clat_stb}, 32'h0);
        tick(); idle();
    endtask

    task automatic t_signature();
        async_cmd(8'h90);
        async_read("R6 sig 00", 18'h0, 32'h20);
        async_read("R6 sig 01", 18'h1, 32'hF0);
        async_read("R6 sig 10", 18'h2, 32'h5);
        async_read("R6 sig 11", 18'h3, 32'h0);
        async_read("R6 sig high bits ignored", 18'h3FFFD, 32'hF0);
        async_cmd(8'h12);
        async_read("R5 unknown code ignored", 18'h0, 32'h20);
        async_cmd(8'hFF);
        async_read("R5 array after FF", 18'h0, 32'h0);
    endtask

    task automatic t_disable();
        idle(); ce_n = 0; oe_n = 0; odis_n = 0;
        #1 chk("R4 odis forces hiz", {31'h0, dout_en}, 32'h0);
        oe_n = 1; odis_n = 1;
        #1 chk("R4 oe high hiz", {31'h0, dout_en}, 32'h0);
        tick(); idle();
    endtask

    task automatic t_lba_async();
        idle(); ce_n = 0; oe_n = 0; tick();
        lba_n = 0;
        #1 chk("R3 lba fall read strobe", {31'h0, rd_stb}, 32'h1);
        chk("R11 no latch in async", {30'h0, alat_stb, clat_stb}, 32'h0);
        tick();
        chk("R3 no strobe once lba low", {31'h0, rd_stb}, 32'h0);
        idle(); tick();
    endtask

    task automatic t_sync_fill();
        async_cmd(8'hE0);
        idle(); ce_n = 0; oe_n = 0;
        #1 chk("R9 no drive before read edge", {31'h0, dout_en}, 32'h0);
        tick(); idle();
        sync_latch(18'hE, 1'b1); sync_wdata(32'hA0A0_0001);
        sync_latch(18'hF, 1'b1); sync_wdata(32'hB0B0_0002);
        sync_latch(18'h0, 1'b1); sync_wdata(32'h0000_00E0);
        sync_latch(18'h1, 1'b1); sync_wdata(32'hD0D0_0004);
        chk("R8 read-latched E0 stored not run", {31'h0, dout_en}, 32'h0);
    endtask

    task automatic t_burst();
        sync_latch(18'h3FFFE, 1'b1);
        idle(); ce_n = 0; oe_n = 0;
        tick();
        chk("R9 burst en", {31'h0, dout_en}, 32'h1);
        chk("R9 burst word 0", dout, 32'hA0A0_0001);
        addr = 18'h5;
        tick(); chk("R10 burst word 1 pins moved", dout, 32'hB0B0_0002);
        tick(); chk("R9 burst wrap word 2", dout, 32'h0000_00E0);
        tick(); chk("R9 burst word 3", dout, 32'hD0D0_0004);
        oe_n = 1; tick();
        oe_n = 0; #1 chk("R9 valid drops after idle edge", {31'h0, dout_en}, 32'h0);
        idle(); tick();
    endtask

    task automatic t_sync_cmd();
        sync_latch(18'h1, 1'b0);
        sync_wdata(32'h90);
        sync_latch(18'h1, 1'b1);
        idle(); ce_n = 0; oe_n = 0; tick();
        chk("R8 sync sig via command", dout, 32'hF0);
        idle(); tick();
        sync_latch(18'h0, 1'b0); sync_wdata(32'hFF);
        sync_latch(18'h0, 1'b0); sync_wdata(32'hE0);
        async_read("R11 back to async", 18'hF, 32'hB0B0_0002);
    endtask

    task automatic t_reset_mid();
        async_cmd(8'hE0);
        idle(); rst_pd_n = 0; ce_n = 0; oe_n = 0;
        #1 chk("R1 reset hiz from sync", {31'h0, dout_en}, 32'h0);
        tick(); rst_pd_n = 1; tick();
        async_read("R1 async and cleared", 18'hE, 32'h0);
    endtask

    initial begin
        rst_pd_n = 0; addr = '0; idle();
        t_reset();
        t_standby();
        t_signature();
        t_disable();
        t_lba_async();
        t_sync_fill();
        t_burst();
        t_sync_cmd();
        t_reset_mid();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule